// File: doc/BRIEF.md
# Memory Encryption Policy Selector

This block sits on the memory request path just ahead of an encryption engine. For every access it decides three things. It decides whether the data must pass through the cipher. It picks which key slot the cipher should use. It removes the page-level encryption marker from the physical address before the address reaches memory. It takes the access type, whether the access comes from a guest, the two marker bits (one from the guest's own tables, one from the host or nested tables), the address-space ID and an I/O flag. Three configuration enables are applied: a global encryption enable, a transparent whole-memory mode and a per-guest virtualization encryption mode.

The decision is registered. A one-entry valid/ready stage gives exactly one cycle of latency and accepts one request per cycle while the consumer is ready. It holds its output unchanged while the consumer stalls. The cipher, key generation and storage, and page-table walking all live elsewhere.

Access type encoding on `req_kind`: 0 is a data access, 1 is an instruction fetch, 2 is a guest page-table access and 3 is a nested page-table access. Key index 0 is the host key. Any other key index equals the guest's address-space ID.

Top module: `mem_crypt_policy`

## Requirements
- R1: With `cfg_enable`=0 and `cfg_transparent`=0, a non-I/O response has encrypt=0, key=0 and error=0, whatever the marker bits are.
- R2: With encryption enabled, no transparent mode and a non-guest, non-I/O access, encrypt equals `req_hmark` and key is 0, for every access type.
- R3: For a guest access while `cfg_virt_enc`=0 (encryption enabled, not transparent, not I/O), encrypt equals `req_hmark`, key is 0, and `req_gmark` has no effect.
- R4: For a guest with `cfg_virt_enc`=1, kind 1 (fetch) and kind 2 (guest page table) are encrypted with key equal to `req_asid`, and both marker bits have no effect.
- R5: For a guest with `cfg_virt_enc`=1, kind 3 (nested page table) has encrypt equal to `req_hmark` and key 0.
- R6: For a guest with `cfg_virt_enc`=1 and kind 0 (data), `req_gmark`=1 gives encrypt=1 with key equal to `req_asid`. `req_gmark`=0 gives encrypt equal to `req_hmark` with key 0.
- R7: With `cfg_transparent`=1, every non-I/O access has encrypt=1, key=0 and error=0, regardless of the enable, guest flag, virtualization mode and marker bits.
- R8: An I/O access always has encrypt=0 and key=0. Its error flag is 1 exactly when either marker bit is set while `cfg_enable` or `cfg_transparent` is 1.
- R9: When R4 or R6 would select the guest key and `req_asid` is 0, the response has error=1, encrypt=0 and key=0.
- R10: When `cfg_enable` or `cfg_transparent` is 1, address bit `cfg_mark_pos` is cleared in `rsp_addr`. A position at or above the address width clears nothing. With both enables 0 the address passes unchanged.
- R11: `req_ready` = !`rsp_valid` | `rsp_ready`. An accepted request appears on the response one clock later. While `rsp_valid`=1 and `rsp_ready`=0, all response outputs hold.
- R12: After a synchronous active-low reset, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Physical address including marker bit |
| req_kind | input | 2 | Access type (0 data, 1 fetch, 2 guest table, 3 nested table) |
| req_guest | input | 1 | Access issued in guest context |
| req_gmark | input | 1 | Guest-table encryption marker |
| req_hmark | input | 1 | Host/nested-table encryption marker |
| req_asid | input | ASID_W | Address-space ID of the issuer |
| req_io | input | 1 | Access targets I/O space |
| cfg_enable | input | 1 | Global memory-encryption enable |
| cfg_transparent | input | 1 | Encrypt all memory with the host key |
| cfg_virt_enc | input | 1 | Per-guest encryption enable |
| cfg_mark_pos | input | POS_W | Bit position of the marker in the address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_addr | output | ADDR_W | Address with marker cleared |
| rsp_encrypt | output | 1 | Route through cipher |
| rsp_key | output | ASID_W | Key slot (0 = host) |
| rsp_error | output | 1 | Policy violation |

## Verification
Directed requests walk each route of the policy in turn: non-guest, guest with the virtualization mode off, each of the four access kinds under the virtualization mode, I/O, disabled and transparent. Each route differs from its neighbours only in the input that should decide it, so a swapped marker or key source shows up directly. A zero address-space ID on a forced-private access, and marker positions above the address width, separate the error and address-clearing edges from the normal paths. A stall window with new requests offered checks that the held response does not change. A long stretch of random configuration and request mixes, with frequent zero IDs and stalls, is then compared every cycle against a behavioural model.

// File: rtl/mcp_pkg.sv
// Package: shared encodings for the memory encryption policy selector.
// Assumes the access kind is carried on two bits by the requester.
package mcp_pkg;

    // Access type carried with each request
    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_GTAB  = 2'd2,
        KIND_NTAB  = 2'd3
    } acc_kind_e;

    // Internal routing class chosen before the key is resolved
    typedef enum logic [2:0] {
        ROUTE_PLAIN      = 3'd0,
        ROUTE_IO         = 3'd1,
        ROUTE_FORCE_HOST = 3'd2,
        ROUTE_HOST_MARK  = 3'd3,
        ROUTE_GUEST      = 3'd4
    } route_e;

    // Key index reserved for the host
    localparam int unsigned HOST_KEY = 0;

endpackage

// File: rtl/mcp_addr_strip.sv
// Module: mcp_addr_strip
// Clears one configurable bit of the physical address, the position of the
// encryption marker. Assumes POS_W can encode every bit index of ADDR_W;
// positions past the top bit leave the address unchanged.
module mcp_addr_strip #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned POS_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [POS_W-1:0]  mark_pos,
    input  logic              strip_en,
    output logic [ADDR_W-1:0] addr_out
);

    // Per-bit mask: one comparator per address bit
    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            logic hit;
            assign hit         = strip_en && (mark_pos == POS_W'(i));
            assign addr_out[i] = addr_in[i] & ~hit;
        end
    endgenerate

endmodule

// File: rtl/mcp_decide.sv
// Module: mcp_decide
// Combinational policy: classifies the access into a route and resolves the
// encrypt flag, key slot and error flag. I/O has top priority, then
// transparent mode, then the global enable, then guest context.
module mcp_decide
    import mcp_pkg::*;
#(
    parameter int unsigned ASID_W = 6
) (
    input  logic [1:0]        kind,
    input  logic              guest,
    input  logic              gmark,
    input  logic              hmark,
    input  logic [ASID_W-1:0] asid,
    input  logic              is_io,
    input  logic              en,
    input  logic              transparent,
    input  logic              virt_enc,
    output logic              encrypt,
    output logic [ASID_W-1:0] key,
    output logic              error
);

    localparam logic [ASID_W-1:0] HOST_IDX = ASID_W'(HOST_KEY);

    acc_kind_e kind_e;
    route_e    route;

    assign kind_e = acc_kind_e'(kind);

    // Pick the routing class from context and access type
    always_comb begin
        if (is_io) begin
            route = ROUTE_IO;
        end else if (transparent) begin
            route = ROUTE_FORCE_HOST;
        end else if (!en) begin
            route = ROUTE_PLAIN;
        end else if (!guest || !virt_enc) begin
            route = ROUTE_HOST_MARK;
        end else begin
            unique case (kind_e)
                KIND_FETCH, KIND_GTAB: route = ROUTE_GUEST;
                KIND_NTAB:             route = ROUTE_HOST_MARK;
                default:               route = gmark ? ROUTE_GUEST : ROUTE_HOST_MARK;
            endcase
        end
    end

    // Resolve the route into encrypt, key and error
    always_comb begin
        encrypt = 1'b0;
        key     = HOST_IDX;
        error   = 1'b0;
        unique case (route)
            ROUTE_IO:         error   = (en || transparent) && (gmark || hmark);
            ROUTE_FORCE_HOST: encrypt = 1'b1;
            ROUTE_HOST_MARK:  encrypt = hmark;
            ROUTE_GUEST: begin
                if (asid == HOST_IDX) begin
                    error = 1'b1;
                end else begin
                    encrypt = 1'b1;
                    key     = asid;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcp_out_reg.sv
// Module: mcp_out_reg
// One-entry valid/ready register stage. Accepts a new payload whenever it is
// empty or its content is being taken; holds otherwise. Assumes the upstream
// keeps its payload stable only in the cycle it is accepted.
module mcp_out_reg #(
    parameter int unsigned PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_data
);

    // Room exists when empty or when the held entry leaves this cycle
    assign in_ready = !out_valid || out_ready;

    // Valid flag: load on room, hold on stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Payload: capture only an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid && in_ready) begin
            out_data <= in_data;
        end
    end

endmodule

// File: rtl/mem_crypt_policy.sv
// Module: mem_crypt_policy (top)
// Per-access encryption decision ahead of a memory cipher: strips the marker
// bit from the address, chooses encrypt / key slot / error and registers the
// result behind a valid/ready stage with one cycle of latency.
// Assumes configuration inputs are stable while requests are in flight.
module mem_crypt_policy #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned ASID_W = 6,
    parameter int unsigned POS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_guest,
    input  logic              req_gmark,
    input  logic              req_hmark,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_io,
    input  logic              cfg_enable,
    input  logic              cfg_transparent,
    input  logic              cfg_virt_enc,
    input  logic [POS_W-1:0]  cfg_mark_pos,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_encrypt,
    output logic [ASID_W-1:0] rsp_key,
    output logic              rsp_error
);

    localparam int unsigned PAY_W = ADDR_W + ASID_W + 2;

    logic [ADDR_W-1:0] clean_addr;
    logic              dec_encrypt;
    logic [ASID_W-1:0] dec_key;
    logic              dec_error;
    logic [PAY_W-1:0]  pay_in;
    logic [PAY_W-1:0]  pay_out;
    logic              strip_en;

    // Marker is meaningful only when some encryption mode is active
    assign strip_en = cfg_enable || cfg_transparent;

    mcp_addr_strip #(
        .ADDR_W (ADDR_W),
        .POS_W  (POS_W)
    ) u_strip (
        .addr_in  (req_addr),
        .mark_pos (cfg_mark_pos),
        .strip_en (strip_en),
        .addr_out (clean_addr)
    );

    mcp_decide #(
        .ASID_W (ASID_W)
    ) u_decide (
        .kind        (req_kind),
        .guest       (req_guest),
        .gmark       (req_gmark),
        .hmark       (req_hmark),
        .asid        (req_asid),
        .is_io       (req_io),
        .en          (cfg_enable),
        .transparent (cfg_transparent),
        .virt_enc    (cfg_virt_enc),
        .encrypt     (dec_encrypt),
        .key         (dec_key),
        .error       (dec_error)
    );

    // Pack the decision for the output stage
    assign pay_in = {clean_addr, dec_encrypt, dec_key, dec_error};

    mcp_out_reg #(
        .PAY_W (PAY_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (pay_in),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (pay_out)
    );

    // Unpack the registered decision
    assign {rsp_addr, rsp_encrypt, rsp_key, rsp_error} = pay_out;

endmodule

// File: rtl/mcp_checker.sv
// Module: mcp_checker
// Property checks for mem_crypt_policy, bound to every instance of the top.
module mcp_checker #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned ASID_W = 6,
    parameter int unsigned POS_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              req_guest,
    input logic              req_gmark,
    input logic              req_hmark,
    input logic [ASID_W-1:0] req_asid,
    input logic              req_io,
    input logic              cfg_enable,
    input logic              cfg_transparent,
    input logic              cfg_virt_enc,
    input logic [POS_W-1:0]  cfg_mark_pos,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_encrypt,
    input logic [ASID_W-1:0] rsp_key,
    input logic              rsp_error
);

    logic fire;
    logic guest_virt;
    assign fire       = req_valid && req_ready;
    assign guest_virt = cfg_enable && !cfg_transparent && !req_io && req_guest && cfg_virt_enc;

    AST_DISABLED_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !cfg_enable && !cfg_transparent && !req_io |=> !rsp_encrypt && !rsp_error); // R1
    AST_HOST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cfg_enable && !cfg_transparent && !req_io && !req_guest
        |=> rsp_encrypt == $past(req_hmark) && rsp_key == '0); // R2
    AST_FORCED_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && guest_virt && (req_kind == 2'd1 || req_kind == 2'd2) && req_asid != '0
        |=> rsp_encrypt && rsp_key == $past(req_asid)); // R4
    AST_DATA_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && guest_virt && req_kind == 2'd0 && req_gmark && req_asid != '0
        |=> rsp_encrypt && rsp_key == $past(req_asid)); // R6
    AST_TRANSPARENT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cfg_transparent && !req_io |=> rsp_encrypt && rsp_key == '0 && !rsp_error); // R7
    AST_IO_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_io |=> !rsp_encrypt && rsp_key == '0); // R8
    AST_ZERO_ASID_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fire && guest_virt && req_kind == 2'd1 && req_asid == '0 |=> rsp_error && !rsp_encrypt); // R9
    AST_MARK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cfg_enable || cfg_transparent) && ({26'd0, cfg_mark_pos} < 32'(ADDR_W))
        |=> ((rsp_addr >> $past(cfg_mark_pos)) & ADDR_W'(1)) == '0); // R10
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_encrypt)
        && $stable(rsp_key) && $stable(rsp_error)); // R11
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid); // R11

endmodule

bind mem_crypt_policy mcp_checker #(
    .ADDR_W (ADDR_W),
    .ASID_W (ASID_W),
    .POS_W  (POS_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_kind        (req_kind),
    .req_guest       (req_guest),
    .req_gmark       (req_gmark),
    .req_hmark       (req_hmark),
    .req_asid        (req_asid),
    .req_io          (req_io),
    .cfg_enable      (cfg_enable),
    .cfg_transparent (cfg_transparent),
    .cfg_virt_enc    (cfg_virt_enc),
    .cfg_mark_pos    (cfg_mark_pos),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_addr        (rsp_addr),
    .rsp_encrypt     (rsp_encrypt),
    .rsp_key         (rsp_key),
    .rsp_error       (rsp_error)
);

// File: tb/test_mem_crypt_policy.sv
// Bench: behavioural reference model compared against the design every clock.
module test_mem_crypt_policy;
    localparam int ADDR_W = 48;
    localparam int ASID_W = 6;
    localparam int POS_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_kind = '0;
    logic req_guest = 1'b0, req_gmark = 1'b0, req_hmark = 1'b0, req_io = 1'b0;
    logic [ASID_W-1:0] req_asid = '0;
    logic cfg_enable = 1'b0, cfg_transparent = 1'b0, cfg_virt_enc = 1'b0;
    logic [POS_W-1:0] cfg_mark_pos = '0;
    logic rsp_valid, rsp_ready = 1'b1;
    logic [ADDR_W-1:0] rsp_addr;
    logic rsp_encrypt, rsp_error;
    logic [ASID_W-1:0] rsp_key;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state: queue holds at most one expected response
    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic enc;
        logic [ASID_W-1:0] key;
        logic err;
        string tag;
    } exp_t;
    exp_t model_q[$];

    always #10 clk = ~clk;

    mem_crypt_policy #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .POS_W(POS_W)) i_mem_crypt_policy (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_guest(req_guest),
        .req_gmark(req_gmark), .req_hmark(req_hmark), .req_asid(req_asid), .req_io(req_io),
        .cfg_enable(cfg_enable), .cfg_transparent(cfg_transparent),
        .cfg_virt_enc(cfg_virt_enc), .cfg_mark_pos(cfg_mark_pos),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_encrypt(rsp_encrypt), .rsp_key(rsp_key), .rsp_error(rsp_error));

    function automatic exp_t ref_policy();
        exp_t e;
        int pos;
        logic priv;
        pos = int'(cfg_mark_pos);
        e.addr = req_addr;
        if ((cfg_enable || cfg_transparent) && pos < ADDR_W) e.addr[pos] = 1'b0;
        e.enc = 1'b0; e.key = '0; e.err = 1'b0; priv = 1'b0;
        if (req_io) begin
            e.tag = "R8";
            e.err = (cfg_enable || cfg_transparent) && (req_gmark || req_hmark);
        end else if (cfg_transparent) begin
            e.tag = "R7"; e.enc = 1'b1;
        end else if (!cfg_enable) begin
            e.tag = "R1";
        end else if (!req_guest) begin
            e.tag = "R2"; e.enc = req_hmark;
        end else if (!cfg_virt_enc) begin
            e.tag = "R3"; e.enc = req_hmark;
        end else begin
            if (req_kind == 2'd1 || req_kind == 2'd2) begin priv = 1'b1; e.tag = "R4"; end
            else if (req_kind == 2'd3) begin priv = 1'b0; e.tag = "R5"; end
            else begin priv = req_gmark; e.tag = "R6"; end
            if (priv) begin
                if (req_asid == 0) begin e.err = 1'b1; e.tag = "R9"; end
                else begin e.enc = 1'b1; e.key = req_asid; end
            end else begin
                e.enc = req_hmark;
            end
        end
        return e;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: check ready, advance model, compare outputs at the falling edge
    task automatic step();
        exp_t nxt;
        logic load;
        #1;
        cmp("R11", "req_ready", 64'(req_ready), 64'(model_q.size() == 0 || rsp_ready));
        load = (model_q.size() == 0) || rsp_ready;
        if (req_valid) nxt = ref_policy();
        @(posedge clk);
        if (load) begin
            model_q.delete();
            if (req_valid) model_q.push_back(nxt);
        end
        @(negedge clk);
        cmp("R11", "rsp_valid", 64'(rsp_valid), 64'(model_q.size() != 0));
        if (model_q.size() != 0 && rsp_valid) begin
            cmp(model_q[0].tag, "encrypt", 64'(rsp_encrypt), 64'(model_q[0].enc));
            cmp(model_q[0].tag, "key", 64'(rsp_key), 64'(model_q[0].key));
            cmp(model_q[0].tag, "error", 64'(rsp_error), 64'(model_q[0].err));
            cmp("R10", "addr", 64'(rsp_addr), 64'(model_q[0].addr));
        end
    endtask

    task automatic cfg(input logic en, input logic tr, input logic virt, input int pos);
        cfg_enable = en; cfg_transparent = tr; cfg_virt_enc = virt; cfg_mark_pos = POS_W'(pos);
    endtask

    task automatic req(input int kind, input logic g, input logic gm, input logic hm,
                       input int asid, input logic io);
        req_valid = 1'b1; req_kind = 2'(kind); req_guest = g; req_gmark = gm; req_hmark = hm;
        req_asid = ASID_W'(asid); req_io = io;
        req_addr = ADDR_W'({$urandom, $urandom}) | (ADDR_W'(1) << 40);
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(7));
        // R12: reset clears the response even with a request offered
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        step();

        cfg(1, 0, 1, 40);
        req(0, 0, 0, 1, 3, 0);   // R2 host marker set
        req(2, 0, 1, 0, 3, 0);   // R2 guest marker ignored for host
        req(1, 1, 0, 0, 5, 0);   // R4 fetch forced private
        req(2, 1, 0, 1, 9, 0);   // R4 guest table forced private
        req(3, 1, 1, 1, 9, 0);   // R5 nested table uses host marker
        req(3, 1, 1, 0, 9, 0);   // R5 nested marker clear
        req(0, 1, 1, 0, 7, 0);   // R6 guest marker private
        req(0, 1, 0, 1, 7, 0);   // R6 shared via host marker
        req(1, 1, 0, 0, 0, 0);   // R9 zero ID
        req(0, 1, 1, 1, 0, 0);   // R9 zero ID on data
        req(0, 1, 0, 1, 4, 1);   // R8 I/O with marker
        req(0, 0, 0, 0, 4, 1);   // R8 I/O without marker
        cfg(1, 0, 0, 40);
        req(0, 1, 1, 0, 7, 0);   // R3 guest marker ignored
        req(1, 1, 0, 1, 7, 0);   // R3 host marker decides
        cfg(0, 0, 1, 40);
        req(0, 1, 1, 1, 7, 0);   // R1 disabled, address unchanged
        req(0, 0, 0, 1, 7, 1);   // R8 I/O no error when disabled
        cfg(0, 1, 1, 40);
        req(1, 1, 0, 0, 0, 0);   // R7 transparent overrides guest
        req(0, 0, 0, 0, 2, 0);   // R7
        cfg(1, 0, 1, 50);
        req(0, 0, 0, 1, 2, 0);   // R10 position past the top
        cfg(1, 0, 1, 0);
        req(0, 0, 0, 0, 2, 0);   // R10 position zero
        // R11 stall: new requests offered while consumer holds
        rsp_ready = 1'b0;
        req(1, 1, 0, 0, 11, 0);
        req(0, 0, 0, 1, 12, 0);
        req(2, 1, 0, 0, 13, 0);
        rsp_ready = 1'b1;
        req_valid = 1'b0;
        step();
        step();

        // Random mixes
        for (int n = 0; n < 4000; n++) begin
            if (n % 50 == 0)
                cfg(1'($urandom), ($urandom % 5) == 0, 1'($urandom), int'($urandom % 64));
            rsp_ready = ($urandom % 4) != 0;
            req_valid = ($urandom % 5) != 0;
            req_kind = 2'($urandom); req_guest = 1'($urandom);
            req_gmark = 1'($urandom); req_hmark = 1'($urandom);
            req_io = ($urandom % 8) == 0;
            req_asid = (($urandom % 6) == 0) ? '0 : ASID_W'($urandom);
            req_addr = ADDR_W'({$urandom, $urandom});
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule